// File: doc/BRIEF.md
# Store Data Lane Formatter

This unit sits between a register source and a doubleword-wide memory write path. It accepts one store request at a time: a 64-bit register value, a size code and a byte-swap flag. It turns the request into write beats. Each beat carries eight byte lanes of data, a byte-enable mask and an offset within a 16-byte window. Byte lane k of `beat_data` (bits 8k+7..8k) is the byte written to address offset + k. Bit 63 of a register is its most significant bit. In big-endian bit numbering that is bit 0, and bits 56..63 form the register's least significant byte.

Stores of 1 to 8 bytes take the low-order bytes of the register. By default they are laid out most-significant byte first. With the swap flag set, the least significant byte goes to the lowest address instead. A 16-byte store takes an even/odd register pair and always leaves as two beats: offset 0 first, then offset 8. The endian-mode input decides which register goes to which half and whether its bytes are reversed.

Both edges use valid/ready. The unit takes one request, stays busy until its last beat is accepted, and only then takes the next request.

Top module: `store_lane_fmt`

## Requirements
- R1: With size code 0 (1 byte), a single beat leaves with `beat_be` = 8'h01, offset 0, `beat_last` = 1, and lane 0 equal to `req_src[7:0]`; the swap flag has no effect on the result.
- R2: With size code 1, 2 or 3 (2, 4 or 8 bytes, N = 2^code) and the swap flag clear, a single beat at offset 0 with `beat_last` = 1 has `beat_be` set in its N lowest bits only, and lane k holds byte N-1-k of `req_src` (byte i being bits 8i+7..8i), so the most significant of the N bytes is at the lowest address.
- R3: With size code 1, 2 or 3 and the swap flag set, lane k holds byte k of `req_src`, so bits 7..0 are at the lowest address, and `beat_be` is the same as in R2.
- R4: Every data lane whose enable bit is clear carries zero.
- R5: With size code 4 (16 bytes) and `req_le` = 0, beat 0 goes to offset 0 with `req_src` (even register) most significant byte first, and beat 1 goes to offset 8 with `req_src_odd` most significant byte first; both beats enable all eight lanes, only beat 1 has `beat_last` set, and the swap flag has no effect.
- R6: With size code 4 and `req_le` = 1, beat 0 goes to offset 0 with `req_src_odd` byte-reversed (lane k = byte k), and beat 1 goes to offset 8 with `req_src` byte-reversed; all lanes are enabled and only beat 1 is last.
- R7: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. The first beat is valid in the next cycle. `req_ready` stays low, and requests are ignored, until the edge at which the last beat is accepted.
- R8: While `beat_valid` is high and `beat_ready` is low, all beat outputs hold their values.
- R9: After reset `req_ready` is 1 and `beat_valid` is 0.
- R10: Size codes 0 to 4 are the only legal codes. `req_le` has no effect on stores of size code 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_size | input | 3 | Size code: 0=1, 1=2, 2=4, 3=8, 4=16 bytes |
| req_rev | input | 1 | Byte-swap flag for sizes 1 to 3 |
| req_le | input | 1 | Endian mode for 16-byte stores, 1 = little-endian |
| req_src | input | 64 | Source register, even register of a 16-byte pair |
| req_src_odd | input | 64 | Odd register of a 16-byte pair |
| beat_valid | output | 1 | Write beat present |
| beat_ready | input | 1 | Write beat accepted |
| beat_data | output | 64 | Beat data, lane k at bits 8k+7..8k |
| beat_be | output | 8 | Byte enables, bit k for lane k |
| beat_offset | output | 4 | Beat address offset, 0 or 8 |
| beat_last | output | 1 | Final beat of the request |

## Verification
The checker assumes that `req_size` carries only codes 0 to 4 whenever `req_valid` is high. It also assumes that the memory side may hold `beat_ready` low for any number of cycles. The bench sweeps only legal size codes and combines every one of them with both flag values and several data patterns. It stalls alternate beats and holds a conflicting request on the input while the unit is busy, so the hold and ignore rules are exercised without ever breaking the size assumption.

// File: rtl/store_lane_fmt.sv
module store_lane_fmt (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_size,
  input  logic        req_rev,
  input  logic        req_le,
  input  logic [63:0] req_src,
  input  logic [63:0] req_src_odd,
  output logic        beat_valid,
  input  logic        beat_ready,
  output logic [63:0] beat_data,
  output logic [7:0]  beat_be,
  output logic [3:0]  beat_offset,
  output logic        beat_last
);

  localparam logic [2:0] SIZE_QUAD = 3'd4;

  logic        busy, phase;
  logic [63:0] h_even, h_odd;
  logic [2:0]  h_size;
  logic        h_rev, h_le;

  function automatic logic [63:0] swap8(input logic [63:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
    return r;
  endfunction

  function automatic logic [63:0] pack_low(input logic [63:0] v, input logic [1:0] lg, input logic rev);
    logic [63:0] r;
    int n;
    n = 1 << lg;
    r = '0;
    for (int k = 0; k < 8; k++)
      if (k < n) r[8*k +: 8] = rev ? v[8*k +: 8] : v[8*(n-1-k) +: 8];
    return r;
  endfunction

  wire quad = (h_size == SIZE_QUAD);

  assign req_ready  = !busy;
  assign beat_valid = busy;

  always_comb begin
    if (quad) begin
      if (!phase) beat_data = h_le ? h_odd : swap8(h_even);
      else        beat_data = h_le ? h_even : swap8(h_odd);
      beat_be     = 8'hFF;
      beat_offset = phase ? 4'd8 : 4'd0;
      beat_last   = phase;
    end else begin
      beat_data   = pack_low(h_even, h_size[1:0], h_rev);
      case (h_size[1:0])
        2'd0:    beat_be = 8'h01;
        2'd1:    beat_be = 8'h03;
        2'd2:    beat_be = 8'h0F;
        default: beat_be = 8'hFF;
      endcase
      beat_offset = 4'd0;
      beat_last   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      h_even <= '0;
      h_odd  <= '0;
      h_size <= '0;
      h_rev  <= 1'b0;
      h_le   <= 1'b0;
    end else if (req_valid && req_ready) begin
      busy   <= 1'b1;
      phase  <= 1'b0;
      h_even <= req_src;
      h_odd  <= req_src_odd;
      h_size <= req_size;
      h_rev  <= req_rev;
      h_le   <= req_le;
    end else if (beat_valid && beat_ready) begin
      if (beat_last) busy <= 1'b0;
      else           phase <= 1'b1;
    end
  end

endmodule

module store_lane_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [2:0]  req_size,
  input logic        beat_valid,
  input logic        beat_ready,
  input logic [63:0] beat_data,
  input logic [7:0]  beat_be,
  input logic [3:0]  beat_offset,
  input logic        beat_last
);

  logic [63:0] lane_mask;
  always_comb
    for (int k = 0; k < 8; k++) lane_mask[8*k +: 8] = {8{beat_be[k]}};

  assert_size_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size <= 3'd4));

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && beat_valid));

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (beat_valid && !req_ready));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data) && $stable(beat_be)
                                     && $stable(beat_offset) && $stable(beat_last)));

  assert_be_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_be[0] && ((beat_be & (beat_be + 8'd1)) == 8'd0)));

  assert_zero_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ((beat_data & ~lane_mask) == 64'd0));

  assert_quad_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last) |=> (beat_valid && beat_last && beat_offset == 4'd8));

  assert_upper_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_offset != 4'd0) |-> (beat_last && beat_be == 8'hFF));

endmodule

bind store_lane_fmt store_lane_fmt_chk chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .beat_data(beat_data), .beat_be(beat_be), .beat_offset(beat_offset),
  .beat_last(beat_last)
);

// File: tb/store_lane_fmt_test.sv
module store_lane_fmt_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_rev = 1'b0, req_le = 1'b0, beat_ready = 1'b0;
  logic [2:0] req_size = 3'd0;
  logic [63:0] req_src = '0, req_src_odd = '0;
  logic req_ready, beat_valid, beat_last;
  logic [63:0] beat_data;
  logic [7:0] beat_be;
  logic [3:0] beat_offset;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  store_lane_fmt uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_rev(req_rev), .req_le(req_le), .req_src(req_src),
    .req_src_odd(req_src_odd), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_data(beat_data), .beat_be(beat_be), .beat_offset(beat_offset),
    .beat_last(beat_last)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, act=%0d cycles exp<=20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic [63:0] v, input int i);
    return 8'((v >> (8*i)) & 64'hFF);
  endfunction

  // expected lanes for a 1..8-byte store, built from arithmetic on the value
  function automatic logic [63:0] exp_small(input logic [63:0] v, input int n, input logic rev);
    logic [63:0] r;
    r = 0;
    for (int k = 0; k < n; k++)
      r = r + (64'(rev ? byte_of(v, k) : byte_of(v, n - 1 - k)) << (8*k));
    return r;
  endfunction

  task automatic check_beat(input string req, input logic [63:0] ed, input logic [7:0] eb,
                            input logic [3:0] eo, input logic el);
    chk(beat_valid == 1'b1, req, "beat_valid", 64'(beat_valid), 64'd1);
    chk(req_ready == 1'b0, "R7", "req_ready while busy", 64'(req_ready), 64'd0);
    chk(beat_data == ed, req, "beat_data", beat_data, ed);
    chk(beat_be == eb, req, "beat_be", 64'(beat_be), 64'(eb));
    chk(beat_offset == eo, req, "beat_offset", 64'(beat_offset), 64'(eo));
    chk(beat_last == el, req, "beat_last", 64'(beat_last), 64'(el));
  endtask

  task automatic run_req(input logic [63:0] ev, input logic [63:0] od, input int sz,
                         input logic rev, input logic le, input int pat);
    int n, nb;
    logic [63:0] ed [2];
    logic [7:0] eb;
    string req;
    n = 1 << sz;
    if (sz == 4) begin
      nb = 2; eb = 8'hFF;
      if (!le) begin
        req = "R5";
        ed[0] = exp_small(ev, 8, 1'b0); ed[1] = exp_small(od, 8, 1'b0);
      end else begin
        req = "R6";
        ed[0] = exp_small(od, 8, 1'b1); ed[1] = exp_small(ev, 8, 1'b1);
      end
    end else begin
      nb = 1;
      eb = 8'((64'd1 << n) - 1);
      ed[0] = exp_small(ev, n, rev);
      ed[1] = 0;
      if (sz == 0) req = "R1";
      else if (rev) req = "R3";
      else req = "R2";
      if (sz == 0) chk(ed[0] == 64'(ev[7:0]), "R1", "swap ignored model", ed[0], 64'(ev[7:0]));
    end
    @(negedge clk);
    req_src = ev; req_src_odd = od; req_size = 3'(sz); req_rev = rev; req_le = le;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R7", "ready when idle", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    // conflicting request held while busy must be ignored
    req_src = ~ev; req_src_odd = ~od; req_size = 3'd0; req_rev = ~rev; req_le = ~le;
    for (int b = 0; b < nb; b++) begin
      check_beat(req, ed[b], eb, b == 1 ? 4'd8 : 4'd0, b == nb - 1);
      if (((pat + b) % 2) == 1) begin
        beat_ready = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_beat("R8", ed[b], eb, b == 1 ? 4'd8 : 4'd0, b == nb - 1);
      end
      beat_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      beat_ready = 1'b0;
    end
    req_valid = 1'b0;
    chk(beat_valid == 1'b0, "R7", "idle after last beat", 64'(beat_valid), 64'd0);
    chk(req_ready == 1'b1, "R7", "ready after last beat", 64'(req_ready), 64'd1);
  endtask

  initial begin
    logic [63:0] pats [4];
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFEDC_BA98_7654_3210;
    pats[2] = 64'h8000_0000_0000_0001;
    pats[3] = 64'hA5C3_0F96_5A3C_F069;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "reset req_ready", 64'(req_ready), 64'd1);
    chk(beat_valid == 1'b0, "R9", "reset beat_valid", 64'(beat_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "req_ready after reset", 64'(req_ready), 64'd1);
    for (int p = 0; p < 4; p++)
      for (int sz = 0; sz < 5; sz++)
        for (int rv = 0; rv < 2; rv++)
          for (int le = 0; le < 2; le++)
            // R10: le toggled on small sizes, expectation does not depend on it
            run_req(pats[p], {pats[p][31:0], ~pats[p][63:32]}, sz, 1'(rv), 1'(le), p + sz + rv);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule